// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines and presents them to a processor as one interrupt output with a vectored acknowledge. Software reaches it through a byte-wide write/read path with a single address bit: address 0 is the command port and address 1 is the data port. Software first writes a start byte to the command port. It then writes a vector base, an optional cascade word and an optional mode word to the data port. After that sequence the data port reaches the 8-bit mask register.

Requests are caught on rising edges in a request register, and masked lines stay out of the priority decision. Input 0 has the highest fixed priority. The interrupt output rises when an unmasked request outranks everything currently in service. A one-cycle acknowledge pulse returns the base plus the winning input number and moves that bit into the in-service register. If no request qualifies at acknowledge, the block returns the vector for input 7 and changes no state. Software ends a service with a specific or non-specific end-of-interrupt command, or the block can retire each interrupt at acknowledge. The command port also holds a lasting selector that picks the request or in-service register for command-port reads.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_o and vec_valid_o are 0, a data-port read returns 0xFF, a command-port read returns the request register (0x00), and data-port writes are ignored until an initialization sequence has completed.
- R2: A command write with bit 4 set starts initialization. Bit 1 of that byte set means no cascade word follows, and bit 0 set means a mode word follows. The next data writes load the vector base, then the cascade word (shown on cas_cfg_o, otherwise left unchanged), then the mode word, in that order. Without a mode word, automatic end-of-interrupt is off.
- R3: Once initialization is complete, a data-port write stores the mask (bit n set masks input n) and a data-port read returns the value last written.
- R4: A rising edge on irq_i[n] sets request bit n. The bit clears when the line falls or when the request is acknowledged. A line held high does not set the bit again.
- R5: int_o is high only after initialization, and only when some unmasked request bit has a lower index than every set in-service bit. Input 0 is highest.
- R6: An inta_i pulse while int_o is high yields, one cycle later, vec_valid_o=1 and vec_o = base + n for the winning input n. Request bit n clears, and in-service bit n is set.
- R7: With mode word bit 1 set (automatic end-of-interrupt), acknowledge leaves the in-service register unchanged.
- R8: An inta_i pulse while int_o is low yields vec_o = base + 7 and changes neither register, even when input 7 is masked.
- R9: Command byte 0x0A selects the request register and 0x0B selects the in-service register for command-port reads. The selection holds across other accesses.
- R10: Command byte 0x60+n clears in-service bit n only.
- R11: Command byte 0x20 clears the lowest-index set in-service bit.
- R12: Starting initialization clears the request and in-service registers and selects the request register for reads. The mask is kept.
- R13: A masked input still sets its request bit but does not raise int_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for one cycle |
| a0_i | input | 1 | Port select: 0 command, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the port a0_i selects |
| irq_i | input | 8 | Request lines, edge triggered |
| inta_i | input | 1 | Acknowledge pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte |
| vec_valid_o | output | 1 | vec_o holds a fresh vector |
| cas_cfg_o | output | 8 | Stored cascade word |

## Verification
Register writes, request edges and end-of-interrupt commands take effect at the next clock edge. Read data and int_o then follow combinationally, so the bench drives on the falling edge and samples at the next falling edge. The vector is registered and appears with vec_valid_o one cycle after the acknowledge pulse. A monitor pops the expected vector from a queue exactly when vec_valid_o is seen on a falling edge. State reads for an acknowledge are made only after that cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int DW = 8;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CAS,
    ST_MODE,
    ST_READY
  } init_st_e;
endpackage

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int N    = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] cas_o,
  output logic          aeoi_o,
  output logic [N-1:0]  mask_o,
  output logic          sel_isr_o,
  output logic          init_o,
  output logic          eoi_ns_o,
  output logic          eoi_sp_o,
  output logic [IW-1:0] eoi_id_o
);
  init_st_e st_q;
  logic need_cas_q, need_mode_q;
  logic cmd_wr, dat_wr, sel_wr, eoi_wr;

  assign cmd_wr   = wr_i & ~a0_i;
  assign dat_wr   = wr_i & a0_i;
  assign init_o   = cmd_wr & wdata_i[4];
  assign sel_wr   = cmd_wr & ~wdata_i[4] & wdata_i[3];
  assign eoi_wr   = cmd_wr & ~wdata_i[4] & ~wdata_i[3];
  assign eoi_ns_o = eoi_wr & (wdata_i[7:5] == 3'b001);
  assign eoi_sp_o = eoi_wr & (wdata_i[7:5] == 3'b011);
  assign eoi_id_o = wdata_i[IW-1:0];
  assign ready_o  = (st_q == ST_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      need_cas_q  <= 1'b0;
      need_mode_q <= 1'b0;
      base_o      <= '0;
      cas_o       <= '0;
      aeoi_o      <= 1'b0;
      mask_o      <= '1;
      sel_isr_o   <= 1'b0;
    end else if (init_o) begin
      st_q        <= ST_BASE;
      need_cas_q  <= ~wdata_i[1];
      need_mode_q <= wdata_i[0];
      aeoi_o      <= 1'b0;
      sel_isr_o   <= 1'b0;
    end else begin
      if (sel_wr && wdata_i[1]) sel_isr_o <= wdata_i[0];
      if (dat_wr) begin
        unique case (st_q)
          ST_BASE: begin
            base_o <= wdata_i;
            st_q   <= need_cas_q ? ST_CAS : (need_mode_q ? ST_MODE : ST_READY);
          end
          ST_CAS: begin
            cas_o <= wdata_i;
            st_q  <= need_mode_q ? ST_MODE : ST_READY;
          end
          ST_MODE: begin
            aeoi_o <= wdata_i[1];
            st_q   <= ST_READY;
          end
          ST_READY: mask_o <= wdata_i[N-1:0];
          default: ;
        endcase
      end
    end
  end

  AST_INIT_SELECTS_IRR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> (!sel_isr_o && !ready_o)); // R12
  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_wr |=> $stable(mask_o)); // R3
endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core
  import prio_irq_pkg::*;
#(
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          inta_i,
  input  logic          ready_i,
  input  logic [N-1:0]  mask_i,
  input  logic [DW-1:0] base_i,
  input  logic          aeoi_i,
  input  logic          init_i,
  input  logic          eoi_ns_i,
  input  logic          eoi_sp_i,
  input  logic [IW-1:0] eoi_id_i,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  isr_o,
  output logic          int_o,
  output logic [DW-1:0] vec_o,
  output logic          vec_valid_o
);
  localparam logic [IW-1:0] SPUR_IDX = IW'(N - 1);

  logic [N-1:0]  prev_q, rise, pend, win_oh, eoi_clr, isr_set, irr_clr;
  logic          pend_v, isr_v, take;
  logic [IW-1:0] pend_idx, isr_idx, vec_idx;

  assign rise = irq_i & ~prev_q;
  assign pend = irr_o & ~mask_i;

  prio_irq_pick #(.N(N)) u_pick_pend (.bits_i(pend),  .valid_o(pend_v), .idx_o(pend_idx));
  prio_irq_pick #(.N(N)) u_pick_isr  (.bits_i(isr_o), .valid_o(isr_v),  .idx_o(isr_idx));

  assign int_o   = ready_i & pend_v & (!isr_v || (pend_idx < isr_idx));
  assign take    = inta_i & int_o;
  assign win_oh  = N'(1) << pend_idx;
  assign irr_clr = take ? win_oh : '0;
  assign isr_set = (take && !aeoi_i) ? win_oh : '0;
  assign vec_idx = take ? pend_idx : SPUR_IDX;

  always_comb begin
    eoi_clr = '0;
    if (eoi_ns_i && isr_v) eoi_clr = N'(1) << isr_idx;
    else if (eoi_sp_i)     eoi_clr = N'(1) << eoi_id_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      irr_o       <= '0;
      isr_o       <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      prev_q      <= irq_i;
      vec_valid_o <= inta_i;
      if (inta_i) vec_o <= base_i + DW'(vec_idx);
      if (init_i) begin
        irr_o <= '0;
        isr_o <= '0;
      end else begin
        irr_o <= (irr_o | rise) & irq_i & ~irr_clr;
        isr_o <= (isr_o & ~eoi_clr) | isr_set;
      end
    end
  end

  AST_INT_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr_o & ~mask_i) != '0)); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (irr_o == '0 && isr_o == '0)); // R12
  AST_AEOI_NO_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aeoi_i && isr_o == '0) |=> (isr_o == '0)); // R7
  AST_SPURIOUS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o) |=> (vec_valid_o && vec_o == $past(base_i) + DW'(N - 1))); // R8
  AST_VALID_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(inta_i)); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               a0_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               inta_i,
  output logic               int_o,
  output logic [DW-1:0]      vec_o,
  output logic               vec_valid_o,
  output logic [DW-1:0]      cas_cfg_o
);
  localparam int IW = $clog2(N_LINES);

  logic               ready, aeoi, sel_isr, init, eoi_ns, eoi_sp;
  logic [DW-1:0]      base;
  logic [N_LINES-1:0] mask, irr, isr;
  logic [IW-1:0]      eoi_id;

  prio_irq_cfg #(.N(N_LINES)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .a0_i, .wdata_i,
    .ready_o(ready), .base_o(base), .cas_o(cas_cfg_o), .aeoi_o(aeoi),
    .mask_o(mask), .sel_isr_o(sel_isr), .init_o(init),
    .eoi_ns_o(eoi_ns), .eoi_sp_o(eoi_sp), .eoi_id_o(eoi_id)
  );

  prio_irq_core #(.N(N_LINES)) u_core (
    .clk_i, .rst_ni, .irq_i, .inta_i,
    .ready_i(ready), .mask_i(mask), .base_i(base), .aeoi_i(aeoi),
    .init_i(init), .eoi_ns_i(eoi_ns), .eoi_sp_i(eoi_sp), .eoi_id_i(eoi_id),
    .irr_o(irr), .isr_o(isr), .int_o, .vec_o, .vec_valid_o
  );

  assign rdata_o = a0_i ? DW'(mask) : (sel_isr ? DW'(isr) : DW'(irr));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, a0_i = 1'b0, inta_i = 1'b0;
  logic [7:0] wdata_i = '0, irq_i = '0;
  logic [7:0] rdata_o, vec_o, cas_cfg_o;
  logic       int_o, vec_valid_o;

  int checks = 0, failures = 0;
  logic [7:0] exp_vec_q[$];
  string      exp_tag_q[$];
  bit         done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (.clk_i(clk), .rst_ni, .wr_i, .a0_i, .wdata_i, .rdata_o,
                     .irq_i, .inta_i, .int_o, .vec_o, .vec_valid_o, .cas_cfg_o);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    @(negedge clk); wr_i = 1'b1; a0_i = a0; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(input string tag, input logic a0, input logic [7:0] exp);
    @(negedge clk); a0_i = a0; #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk); irq_i[n] = v;
    @(negedge clk);
  endtask

  task automatic ack(input string tag, input logic [7:0] exp);
    exp_vec_q.push_back(exp);
    exp_tag_q.push_back(tag);
    @(negedge clk); inta_i = 1'b1;
    @(negedge clk); inta_i = 1'b0;
  endtask

  // monitor: pops expected vectors as the design presents them
  always @(negedge clk) begin
    if (rst_ni && vec_valid_o) begin
      if (exp_vec_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R6 actual=%02h expected=none", vec_o);
      end else begin
        automatic logic [7:0] e = exp_vec_q.pop_front();
        automatic string t = exp_tag_q.pop_front();
        chk(t, vec_o, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1 int_o", {7'd0, int_o}, 8'h00);
    chk("R1 vec_valid_o", {7'd0, vec_valid_o}, 8'h00);
    rd("R1 mask", 1'b1, 8'hFF);
    rd("R1 irr", 1'b0, 8'h00);
    wr(1'b1, 8'h00);
    rd("R1 data ignored before init", 1'b1, 8'hFF);

    // R2 full init: base 0x20, cascade 0x04, mode without auto end
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    @(negedge clk); #1; chk("R2 cascade", cas_cfg_o, 8'h04);
    wr(1'b1, 8'hA5); rd("R3 mask A5", 1'b1, 8'hA5);
    wr(1'b1, 8'h00); rd("R3 mask 00", 1'b1, 8'h00);

    line(3, 1'b1);
    rd("R4 irr edge", 1'b0, 8'h08);
    #0 chk("R5 int on pending", {7'd0, int_o}, 8'h01);
    line(1, 1'b1);
    ack("R6 vector input 1", 8'h21);
    wr(1'b0, 8'h0B);
    rd("R6 isr bit1", 1'b0, 8'h02);
    #0 chk("R5 lower prio blocked", {7'd0, int_o}, 8'h00);
    wr(1'b1, 8'h00);
    rd("R9 select persists", 1'b0, 8'h02);

    wr(1'b0, 8'h20);
    rd("R11 nonspecific eoi", 1'b0, 8'h00);
    #0 chk("R5 int after eoi", {7'd0, int_o}, 8'h01);
    ack("R6 vector input 3", 8'h23);
    rd("R6 isr bit3", 1'b0, 8'h08);

    line(0, 1'b1);
    #0 chk("R5 higher prio preempts", {7'd0, int_o}, 8'h01);
    ack("R6 vector input 0", 8'h20);
    rd("R6 isr bits0,3", 1'b0, 8'h09);
    wr(1'b0, 8'h63);
    rd("R10 specific eoi 3", 1'b0, 8'h01);
    wr(1'b0, 8'h20);
    rd("R11 nonspecific eoi 0", 1'b0, 8'h00);

    wr(1'b0, 8'h0A);
    rd("R4 held lines no rerequest", 1'b0, 8'h00);
    line(0, 1'b0); line(1, 1'b0); line(3, 1'b0);

    wr(1'b1, 8'h90);
    line(4, 1'b1);
    rd("R13 masked latched", 1'b0, 8'h10);
    #0 chk("R13 masked no int", {7'd0, int_o}, 8'h00);

    line(2, 1'b1);
    #0 chk("R5 int input 2", {7'd0, int_o}, 8'h01);
    line(2, 1'b0);
    rd("R4 falling clears", 1'b0, 8'h10);
    ack("R8 spurious vector", 8'h27);
    wr(1'b0, 8'h0B);
    rd("R8 isr untouched", 1'b0, 8'h00);

    // second init: single, mode word with auto end; isr selected beforehand
    wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h02);
    @(negedge clk); #1; chk("R2 cascade kept", cas_cfg_o, 8'h04);
    rd("R3 mask kept", 1'b1, 8'h90);
    rd("R12 irr cleared", 1'b0, 8'h00);
    line(6, 1'b1);
    rd("R12 irr selected", 1'b0, 8'h40);
    ack("R7 vector input 6", 8'h46);
    rd("R6 irr cleared by ack", 1'b0, 8'h00);
    wr(1'b0, 8'h0B);
    rd("R7 isr stays clear", 1'b0, 8'h00);
    #0 chk("R7 no int", {7'd0, int_o}, 8'h00);

    // third init: cascade word but no mode word
    wr(1'b0, 8'h10); wr(1'b1, 8'h80); wr(1'b1, 8'h02);
    @(negedge clk); #1; chk("R2 cascade new", cas_cfg_o, 8'h02);
    rd("R2 data went to init", 1'b1, 8'h90);
    line(6, 1'b0);
    line(5, 1'b1);
    ack("R2 vector base 80", 8'h85);
    wr(1'b0, 8'h0B);
    rd("R2 auto end off", 1'b0, 8'h20);

    repeat (2) @(negedge clk);
    chk("R6 all vectors seen", 8'(exp_vec_q.size()), 8'h00);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule